// File: doc/BRIEF.md
# Periodic Interrupt Timer with Indexed Register Access

This block produces a periodic interrupt and a matching square wave from a 32768 Hz time-base enable. A host CPU reaches its registers through two ports: an index port that selects a register, and a data port that reads or writes the selected register. A four-bit rate code picks one of thirteen power-of-two periods. A pending flag records each period boundary and is cleared when the host reads it. An enable bit decides whether that flag drives the interrupt request pin.

The index write also carries a separate mask bit, which goes straight out on its own pin to gate a non-maskable interrupt elsewhere. The divider is a free-running counter. Changing the rate code therefore never restarts or shifts the underlying count. Calendar counting, battery-backed storage and the interrupt controller sit outside this block.

Top module: `tick_irq_unit`

## Requirements
- R1: After reset, control register A (index 0x0A) reads 0x06, control register B (index 0x0B) reads 0x00, flag register C (index 0x0C) reads 0x00, and `irq`, `sqw` and `nmi_mask` are low.
- R2: A write with `port_sel`=0 loads the index. `wdata[6:0]` select the register that later data-port accesses (`port_sel`=1) reach, and `wdata[7]` appears on `nmi_mask` from the next cycle.
- R3: With rate code r (bits 3:0 of register A) in 3..15, a divider event occurs on every tick that brings the count of `tick_en` pulses since reset to a multiple of 2^(r-1). The first event therefore follows 2^(r-1) ticks.
- R4: Writing a new rate code does not restart the tick count. The next event falls at the next multiple of the new period, counted from reset.
- R5: Rate codes 0, 1 and 2 produce no divider event and hold `sqw` low.
- R6: For a legal rate, `sqw` is high during the second half of each period. It is high when the tick count modulo 2^(r-1) is at least 2^(r-2), so it falls in the cycle the event flag sets.
- R7: Register C bit 6 is the pending flag. It is set by every divider event whether or not the interrupt is enabled. Bit 7 mirrors `irq`, and bits 5:0 read 0.
- R8: `irq` is high exactly when the pending flag is set and register B bit 6 is set. Clearing that bit drops `irq` in the next cycle while the flag stays set.
- R9: A data-port read of register C clears the pending flag, so `irq` is low from the next cycle. A divider event in that same cycle sets the flag again.
- R10: Status register D (index 0x0D) always reads 0x80. Data-port writes to registers C and D change nothing.
- R11: Registers A and B read back the full byte last written. A read returns its value on `rdata` in the cycle after `rd_en`. Data reads of any other index return 0, and index-port reads return {`nmi_mask`, index}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | 32768 Hz time-base enable, one cycle per tick |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| port_sel | input | 1 | 0 = index port, 1 = data port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Periodic interrupt request |
| sqw | output | 1 | Square-wave output at the selected rate |
| nmi_mask | output | 1 | Non-maskable interrupt mask from index bit 7 |

## Verification
The bench builds the block with its default parameters: a 14-bit counter, which covers every legal rate up to code 15. It drives `tick_en` once per clock during tick bursts, so that a full 16384-tick period at the slowest rate fits comfortably in the run. It keeps its own tick count, so it can predict the exact tick of each event after a rate change in the middle of a period. This exposes any design that restarts the counter when the rate changes.

// File: rtl/tick_irq_pkg.sv
package tick_irq_pkg;
    localparam int IDX_W    = 7;
    localparam int DATA_W   = 8;
    localparam int RATE_W   = 4;
    localparam int MIN_RATE = 3;
    localparam int MAX_RATE = 15;
    localparam int CNT_W    = MAX_RATE - 1;
    localparam int EN_BIT   = 6;

    localparam logic [IDX_W-1:0]  IDX_CTRL_A = 7'h0A;
    localparam logic [IDX_W-1:0]  IDX_CTRL_B = 7'h0B;
    localparam logic [IDX_W-1:0]  IDX_FLAGS  = 7'h0C;
    localparam logic [IDX_W-1:0]  IDX_STAT_D = 7'h0D;
    localparam logic [DATA_W-1:0] CTRL_A_RST = 8'h06;
    localparam logic [DATA_W-1:0] STAT_D_VAL = 8'h80;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic              nmi;
        logic [DATA_W-1:0] ctrl_a;
        logic [DATA_W-1:0] ctrl_b;
        logic              flag;
        logic [DATA_W-1:0] rdata;
    } regs_t;
endpackage

// File: rtl/tick_divider.sv
module tick_divider
    import tick_irq_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int RW = RATE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [RW-1:0] rate,
    output logic          ev,
    output logic          sqw
);
    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] mask;
    logic [CW-1:0] half;
    logic          rate_ok;

    always_comb begin
        rate_ok = (int'(rate) >= MIN_RATE) && (int'(rate) <= CW + 1);
        mask    = '0;
        if (rate_ok) begin
            mask = ~({CW{1'b1}} << (rate - RW'(1)));
        end
        half  = mask ^ (mask >> 1);
        ev    = tick && rate_ok && ((cnt_q & mask) == mask);
        sqw   = rate_ok && (|(cnt_q & half));
        cnt_d = cnt_q;
        if (tick) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/tick_regs.sv
module tick_regs
    import tick_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              port_sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ev,
    output logic [DATA_W-1:0] rdata,
    output logic [RATE_W-1:0] rate,
    output logic              irq,
    output logic              nmi_mask,
    output logic [IDX_W-1:0]  cur_idx
);
    regs_t             r_d, r_q;
    logic [DATA_W-1:0] sel_val;
    logic              irq_now;

    always_comb begin
        r_d     = r_q;
        irq_now = r_q.flag && r_q.ctrl_b[EN_BIT];

        unique case (r_q.idx)
            IDX_CTRL_A: sel_val = r_q.ctrl_a;
            IDX_CTRL_B: sel_val = r_q.ctrl_b;
            IDX_FLAGS:  sel_val = {irq_now, r_q.flag, {(DATA_W-2){1'b0}}};
            IDX_STAT_D: sel_val = STAT_D_VAL;
            default:    sel_val = '0;
        endcase

        if (wr_en && !port_sel) begin
            r_d.nmi = wdata[DATA_W-1];
            r_d.idx = wdata[IDX_W-1:0];
        end
        if (wr_en && port_sel) begin
            if (r_q.idx == IDX_CTRL_A) r_d.ctrl_a = wdata;
            if (r_q.idx == IDX_CTRL_B) r_d.ctrl_b = wdata;
        end

        if (rd_en) begin
            r_d.rdata = port_sel ? sel_val : {r_q.nmi, r_q.idx};
            if (port_sel && (r_q.idx == IDX_FLAGS)) begin
                r_d.flag = 1'b0;
            end
        end
        if (ev) begin
            r_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.ctrl_a <= CTRL_A_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign rdata    = r_q.rdata;
    assign rate     = r_q.ctrl_a[RATE_W-1:0];
    assign irq      = r_q.flag && r_q.ctrl_b[EN_BIT];
    assign nmi_mask = r_q.nmi;
    assign cur_idx  = r_q.idx;
endmodule

// File: rtl/tick_irq_unit.sv
module tick_irq_unit
    import tick_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              port_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              sqw,
    output logic              nmi_mask
);
    logic              div_ev;
    logic [RATE_W-1:0] rate_code;
    logic [IDX_W-1:0]  cur_idx;

    tick_divider #(.CW(CNT_W), .RW(RATE_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_en),
        .rate  (rate_code),
        .ev    (div_ev),
        .sqw   (sqw)
    );

    tick_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .port_sel (port_sel),
        .wdata    (wdata),
        .ev       (div_ev),
        .rdata    (rdata),
        .rate     (rate_code),
        .irq      (irq),
        .nmi_mask (nmi_mask),
        .cur_idx  (cur_idx)
    );
endmodule

// File: rtl/tick_irq_chk.sv
module tick_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic       port_sel,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       irq,
    input logic       sqw,
    input logic       nmi_mask,
    input logic       div_ev,
    input logic [3:0] rate_code,
    input logic [6:0] cur_idx
);
    p_no_event_bad_rate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_code < 4'd3) |-> (!div_ev && !sqw));

    p_nmi_from_index_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !port_sel) |=> (nmi_mask == $past(wdata[7])));

    p_clear_on_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && port_sel && cur_idx == 7'h0C && !div_ev) |=> !irq);

    p_status_const_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && port_sel && cur_idx == 7'h0D) |=> (rdata == 8'h80));

    p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(div_ev) || $past(wr_en && port_sel)));
endmodule

bind tick_irq_unit tick_irq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .port_sel  (port_sel),
    .wdata     (wdata),
    .rdata     (rdata),
    .irq       (irq),
    .sqw       (sqw),
    .nmi_mask  (nmi_mask),
    .div_ev    (div_ev),
    .rate_code (rate_code),
    .cur_idx   (cur_idx)
);

// File: tb/tick_irq_unit_test.sv
`timescale 1ns/1ps
module tick_irq_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       port_sel = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq, sqw, nmi_mask;

    int tests = 0;
    int fails = 0;
    int ticks = 0;
    bit done  = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    tick_irq_unit uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .rd_en(rd_en), .port_sel(port_sel), .wdata(wdata), .rdata(rdata),
        .irq(irq), .sqw(sqw), .nmi_mask(nmi_mask)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // monitor: pops the expected read value once the registered data lands
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en) begin
                @(negedge clk);
                if (exp_q.size() != 0) begin
                    check(tag_q.pop_front(), rdata, exp_q.pop_front());
                end
            end
        end
    end

    task automatic pulse(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en = 1'b1;
            ticks++;
        end
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic wr_index(logic [7:0] v);
        @(negedge clk);
        port_sel = 1'b0; wdata = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_reg(logic [6:0] idx, logic [7:0] v);
        wr_index({1'b0, idx});
        @(negedge clk);
        port_sel = 1'b1; wdata = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_reg(logic [6:0] idx, logic [7:0] exp, string tag);
        wr_index({1'b0, idx});
        @(negedge clk);
        port_sel = 1'b1; rd_en = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic to_event(int rate, string tag);
        int period = 1 << (rate - 1);
        int need   = period - (ticks % period);
        if (need > 1) pulse(need - 1);
        check({tag, " before event"}, {7'd0, irq}, 8'd0);
        pulse(1);
        check({tag, " at event"}, {7'd0, irq}, 8'd1);
        rd_reg(7'h0C, 8'hC0, {tag, " flags R7"});
        check({tag, " cleared R9"}, {7'd0, irq}, 8'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", {7'd0, irq}, 8'd0);
        check("R1 sqw", {7'd0, sqw}, 8'd0);
        check("R1 nmi_mask", {7'd0, nmi_mask}, 8'd0);
        rd_reg(7'h0A, 8'h06, "R1 ctrl A");
        rd_reg(7'h0B, 8'h00, "R1 ctrl B");
        rd_reg(7'h0C, 8'h00, "R1 flags C");
        rd_reg(7'h0D, 8'h80, "R10 status D");

        // R2 index bit 7 drives nmi_mask
        wr_index(8'h8A);
        check("R2 nmi set", {7'd0, nmi_mask}, 8'd1);
        rd_reg(7'h0A, 8'h06, "R2 index selects A");
        check("R2 nmi cleared", {7'd0, nmi_mask}, 8'd0);

        // R3 R6 default rate 6, enable off
        pulse(15);
        check("R6 sqw low first half", {7'd0, sqw}, 8'd0);
        pulse(1);
        check("R6 sqw high second half", {7'd0, sqw}, 8'd1);
        pulse(15);
        rd_reg(7'h0C, 8'h00, "R3 no flag before period");
        pulse(1);
        check("R8 irq gated off", {7'd0, irq}, 8'd0);
        check("R6 sqw falls at event", {7'd0, sqw}, 8'd0);
        rd_reg(7'h0C, 8'h40, "R7 flag set while disabled");
        rd_reg(7'h0C, 8'h00, "R9 flag cleared by read");

        // R8 enable interrupt
        wr_reg(7'h0B, 8'h40);
        rd_reg(7'h0B, 8'h40, "R11 ctrl B readback");
        to_event(6, "R3 rate 6");

        // R3 fastest rate, then R4 rate change mid period
        wr_reg(7'h0A, 8'h03);
        to_event(3, "R3 rate 3");
        pulse(2);
        wr_reg(7'h0A, 8'h24);
        rd_reg(7'h0A, 8'h24, "R11 ctrl A readback");
        to_event(4, "R4 rate 4 after change");

        // R5 illegal rates
        wr_reg(7'h0A, 8'h02);
        pulse(40);
        check("R5 rate 2 sqw", {7'd0, sqw}, 8'd0);
        rd_reg(7'h0C, 8'h00, "R5 rate 2 no flag");
        wr_reg(7'h0A, 8'h01);
        pulse(20);
        rd_reg(7'h0C, 8'h00, "R5 rate 1 no flag");
        wr_reg(7'h0A, 8'h00);
        pulse(20);
        rd_reg(7'h0C, 8'h00, "R5 rate 0 no flag");

        // R3 slowest rate
        wr_reg(7'h0A, 8'h0F);
        to_event(15, "R3 rate 15");

        // R8 disabling drops irq, flag remains
        wr_reg(7'h0A, 8'h03);
        to_event(3, "R3 rate 3 again");
        pulse(4);
        check("R8 irq up", {7'd0, irq}, 8'd1);
        wr_reg(7'h0B, 8'h00);
        check("R8 irq drops on disable", {7'd0, irq}, 8'd0);
        rd_reg(7'h0C, 8'h40, "R8 flag kept while disabled");

        // R10 ignored writes, R11 unused index
        wr_reg(7'h0C, 8'hFF);
        rd_reg(7'h0C, 8'h00, "R10 write to C ignored");
        wr_reg(7'h0D, 8'h00);
        rd_reg(7'h0D, 8'h80, "R10 write to D ignored");
        rd_reg(7'h20, 8'h00, "R11 unused index");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule